// File: doc/BRIEF.md
# Accumulator ALU with Packed-Decimal Adjust

This block is the arithmetic and logic stage of an 8-bit style accumulator processor. Its word width is a parameter. The default is 8 bits, and a 16-bit build is also supported. Each cycle it takes the accumulator, a memory operand, the incoming carry, overflow and decimal flags, and a 3-bit operation code. On the next rising clock edge it registers a result word and the updated negative, overflow, zero and carry flags.

Eight operations are supported: add with carry, subtract with borrow, shift left, rotate left, rotate right, increment, decrement and bit test. The shift, rotate, increment and decrement operations act on the memory operand. The bit test leaves the accumulator unchanged on the result port.

Add and subtract also have a packed-decimal mode, which corrects the two nibbles of the low byte. In a wider build the bits above the low byte carry the plain binary result.

The sign flag sits at the top bit of the configured width, and the overflow source sits one bit below it. Every flag position therefore moves with the width parameter. Decoding, register files and memory access are handled elsewhere.

Top module: `acc_alu`

## Requirements
- R1: While rst_ni is low, res_o and all four flag outputs are 0, whatever the other inputs are.
- R2: With op_i = 0 (add) and dec_i = 0, one clock after the inputs are applied, res_o = (a_i + m_i + carry_i) mod 2^W. c_o is the carry out of bit W-1. v_o is the sign bit of ~(a_i^m_i) & (a_i^res_o). n_o is bit W-1 of res_o, and z_o is 1 exactly when res_o is 0.
- R3: With op_i = 1 (subtract) and dec_i = 0, res_o = (a_i + ~m_i + carry_i) mod 2^W. c_o is the carry out of that sum. v_o is the sign bit of (a_i^m_i) & (a_i^res_o). n_o and z_o are taken from res_o.
- R4: With op_i = 0 and dec_i = 1, the low nibble sum is a_i[3:0] + m_i[3:0] + carry_i. If it is above 9, 6 is added to it and a nibble carry passes up. The high nibble sum (with that carry) is corrected the same way, and c_o is set exactly when the high nibble sum is above 9. res_o[7:0] is the two corrected nibbles. Any bits above 7 are the binary sum's bits.
- R5: With op_i = 1 and dec_i = 1, the nibble sums use ~m_i. If a nibble produces no carry out of 4 bits, 10 is added to it (mod 16). c_o is the binary carry out of bit 7. Any bits above 7 are the binary difference's bits.
- R6: In decimal add and subtract, n_o, v_o and z_o come from the uncorrected binary result of R2 or R3, not from the corrected res_o.
- R7: op_i = 2 shifts m_i left with a 0 entering bit 0. c_o takes old m_i[W-1], and n_o and z_o follow res_o.
- R8: op_i = 3 shifts m_i left with carry_i entering bit 0. c_o takes old m_i[W-1].
- R9: op_i = 4 shifts m_i right with carry_i entering bit W-1. c_o takes old m_i[0].
- R10: op_i = 5 gives m_i+1 and op_i = 6 gives m_i-1, both wrapping mod 2^W. Only n_o and z_o change. c_o equals carry_i and v_o equals ovf_i. The shift and rotate operations also pass ovf_i to v_o.
- R11: op_i = 7 (bit test) returns a_i on res_o. It sets z_o when a_i & m_i is 0, n_o = m_i[W-1], v_o = m_i[W-2], and c_o = carry_i.
- R12: dec_i has no effect on op_i values 2 to 7.
- R13: In a 16-bit build, the sign is bit 15 and the overflow source for bit test is bit 14. The decimal correction applies to bits 7:0 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code, 0..7 as listed in the requirements |
| a_i | input | W | Accumulator |
| m_i | input | W | Memory operand |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| dec_i | input | 1 | Decimal mode flag |
| res_o | output | W | Registered result |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |

## Verification
Decimal correction and binary flag generation happen in the same cycle, and they take their inputs from different sums. That separation is what needs proving. A full sweep of every valid packed-decimal operand pair, with both carry values, creates cases where the two sums disagree. For example, 99 plus 01 returns a zero byte while the zero flag stays clear, and 09 plus 01 returns 10 while the binary sum is 0x0A. Each case is judged against an arithmetic model that builds the binary flags and the corrected nibbles separately.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_SHL = 3'd2,
    OP_RLC = 3'd3,
    OP_RRC = 3'd4,
    OP_INC = 3'd5,
    OP_DEC = 3'd6,
    OP_TST = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         sub_i,
  input  logic         cin_i,
  input  logic         dec_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] m_eff;
  logic [W:0]   sum;
  logic [W-1:0] r_bin;
  logic [W-1:0] dec_res;
  logic [4:0]   lo_s, hi_s;
  logic [3:0]   lo_a, hi_a;
  logic         hc, dc;

  assign m_eff = sub_i ? ~m_i : m_i;
  assign sum   = {1'b0, a_i} + {1'b0, m_eff} + {{W{1'b0}}, cin_i};
  assign r_bin = sum[W-1:0];

  // nibble correction on the low byte only
  always_comb begin
    lo_s = {1'b0, a_i[3:0]} + {1'b0, m_eff[3:0]} + {4'b0, cin_i};
    if (sub_i) begin
      hc   = lo_s[4];
      lo_a = hc ? lo_s[3:0] : lo_s[3:0] + 4'd10;
    end else begin
      hc   = (lo_s > 5'd9);
      lo_a = hc ? lo_s[3:0] + 4'd6 : lo_s[3:0];
    end
    hi_s = {1'b0, a_i[7:4]} + {1'b0, m_eff[7:4]} + {4'b0, hc};
    if (sub_i) begin
      dc   = hi_s[4];
      hi_a = dc ? hi_s[3:0] : hi_s[3:0] + 4'd10;
    end else begin
      dc   = (hi_s > 5'd9);
      hi_a = dc ? hi_s[3:0] + 4'd6 : hi_s[3:0];
    end
  end

  if (W > 8) begin : g_wide
    assign dec_res = {r_bin[W-1:8], hi_a, lo_a};
  end else begin : g_byte
    assign dec_res = {hi_a, lo_a};
  end

  assign res_o = dec_i ? dec_res : r_bin;
  assign c_o   = dec_i ? dc : sum[W];
  assign n_o   = r_bin[MSB];
  assign z_o   = ~|r_bin;
  assign v_o   = (sub_i ? (a_i[MSB] ^ m_i[MSB]) : ~(a_i[MSB] ^ m_i[MSB]))
               & (a_i[MSB] ^ r_bin[MSB]);
endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    res_o = m_i;
    c_o   = cin_i;
    unique case (op_i)
      OP_SHL: begin res_o = {m_i[W-2:0], 1'b0};  c_o = m_i[W-1]; end
      OP_RLC: begin res_o = {m_i[W-2:0], cin_i}; c_o = m_i[W-1]; end
      OP_RRC: begin res_o = {cin_i, m_i[W-1:1]}; c_o = m_i[0];   end
      OP_INC: res_o = m_i + {{(W-1){1'b0}}, 1'b1};
      OP_DEC: res_o = m_i - {{(W-1){1'b0}}, 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  input  logic         dec_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o
);
  localparam int MSB = W - 1;

  alu_op_e      op;
  logic [W-1:0] as_res, un_res, res_d, res_q;
  logic         as_n, as_v, as_z, as_c, un_c;
  alu_flags_t   flg_d, flg_q;

  assign op = alu_op_e'(op_i);

  acc_alu_addsub #(.W(W)) u_addsub (
    .a_i   (a_i),
    .m_i   (m_i),
    .sub_i (op == OP_SUB),
    .cin_i (carry_i),
    .dec_i (dec_i),
    .res_o (as_res),
    .n_o   (as_n),
    .v_o   (as_v),
    .z_o   (as_z),
    .c_o   (as_c)
  );

  acc_alu_unary #(.W(W)) u_unary (
    .op_i  (op),
    .m_i   (m_i),
    .cin_i (carry_i),
    .res_o (un_res),
    .c_o   (un_c)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_d = as_res;
        flg_d = '{n: as_n, v: as_v, z: as_z, c: as_c};
      end
      OP_TST: begin
        res_d = a_i;
        flg_d = '{n: m_i[MSB], v: m_i[MSB-1], z: ~|(a_i & m_i), c: carry_i};
      end
      default: begin
        res_d = un_res;
        flg_d = '{n: un_res[MSB], v: ovf_i, z: ~|un_res, c: un_c};
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign res_o = res_q;
  assign n_o   = flg_q.n;
  assign v_o   = flg_q.v;
  assign z_o   = flg_q.z;
  assign c_o   = flg_q.c;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] m_i,
  input logic         carry_i,
  input logic         ovf_i,
  input logic         dec_i,
  input logic [W-1:0] res_o,
  input logic         n_o,
  input logic         v_o,
  input logic         z_o,
  input logic         c_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_add_nz_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(op_i) == OP_ADD && !$past(dec_i)) |-> (z_o == (res_o == '0)) && (n_o == res_o[W-1]));

  assert_sub_nz_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(op_i) == OP_SUB && !$past(dec_i)) |-> (z_o == (res_o == '0)) && (n_o == res_o[W-1]));

  assert_shl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(op_i) == OP_SHL) |-> (res_o[0] == 1'b0) && (c_o == $past(m_i[W-1])));

  assert_rlc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(op_i) == OP_RLC) |-> (res_o[0] == $past(carry_i)) && (c_o == $past(m_i[W-1])));

  assert_rrc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(op_i) == OP_RRC) |-> (res_o[W-1] == $past(carry_i)) && (c_o == $past(m_i[0])));

  assert_incdec_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(op_i) == OP_INC || $past(op_i) == OP_DEC) |-> (c_o == $past(carry_i)) && (v_o == $past(ovf_i)));

  assert_tst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(op_i) == OP_TST) |-> (res_o == $past(a_i)) && (n_o == $past(m_i[W-1]))
                               && (v_o == $past(m_i[W-2])) && (c_o == $past(carry_i)));

  assert_shl_dec_R12: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(op_i) == OP_SHL && $past(dec_i)) |-> (res_o == {$past(m_i[W-2:0]), 1'b0}));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .a_i     (a_i),
  .m_i     (m_i),
  .carry_i (carry_i),
  .ovf_i   (ovf_i),
  .dec_i   (dec_i),
  .res_o   (res_o),
  .n_o     (n_o),
  .v_o     (v_o),
  .z_o     (z_o),
  .c_o     (c_o)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  op8 = '0, op16 = '0;
  logic [7:0]  a8 = '0, m8 = '0;
  logic [15:0] a16 = '0, m16 = '0;
  logic        c8 = 1'b0, v8 = 1'b0, d8 = 1'b0;
  logic        c16 = 1'b0, v16 = 1'b0, d16 = 1'b0;
  logic [7:0]  r8;
  logic [15:0] r16;
  logic        n8, vo8, z8, co8, n16, vo16, z16, co16;

  int checks = 0;
  int fails = 0;

  acc_alu #(.W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op8), .a_i(a8), .m_i(m8),
    .carry_i(c8), .ovf_i(v8), .dec_i(d8),
    .res_o(r8), .n_o(n8), .v_o(vo8), .z_o(z8), .c_o(co8)
  );

  acc_alu #(.W(16)) u_dut16 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op16), .a_i(a16), .m_i(m16),
    .carry_i(c16), .ovf_i(v16), .dec_i(d16),
    .res_o(r16), .n_o(n16), .v_o(vo16), .z_o(z16), .c_o(co16)
  );

  // arithmetic reference built from the requirements
  function automatic void model(input int w, input int op, input int a, input int m,
                                input int c, input int v, input int d,
                                output int r, output int fn, output int fv,
                                output int fz, output int fc);
    int msk, sb, s, mi, lo, hi, hc;
    msk = (1 << w) - 1;
    sb  = 1 << (w - 1);
    fv  = v;
    fc  = c;
    r   = 0;
    fn  = 0;
    fz  = 0;
    case (op)
      0, 1: begin
        mi = (op == 1) ? (~m & msk) : m;
        s  = a + mi + c;
        r  = s & msk;
        fc = (s > msk) ? 1 : 0;
        if (op == 0) fv = ((~(a ^ m)) & (a ^ r) & sb) != 0;
        else         fv = ((a ^ m) & (a ^ r) & sb) != 0;
        fn = (r & sb) != 0;
        fz = (r == 0);
        if (d != 0) begin
          lo = (a & 15) + (mi & 15) + c;
          if (op == 0) begin hc = (lo > 9) ? 1 : 0; if (hc != 0) lo += 6; end
          else begin hc = (lo > 15) ? 1 : 0; if (hc == 0) lo += 10; end
          hi = ((a >> 4) & 15) + ((mi >> 4) & 15) + hc;
          if (op == 0) begin fc = (hi > 9) ? 1 : 0; if (fc != 0) hi += 6; end
          else begin fc = (hi > 15) ? 1 : 0; if (fc == 0) hi += 10; end
          r = (r & msk & ~255) | ((hi & 15) << 4) | (lo & 15);
        end
      end
      7: begin
        r  = a;
        fn = (m & sb) != 0;
        fv = (m & (sb >> 1)) != 0;
        fz = ((a & m) == 0);
      end
      default: begin
        case (op)
          2: begin r = (m << 1) & msk; fc = (m & sb) != 0; end
          3: begin r = ((m << 1) | c) & msk; fc = (m & sb) != 0; end
          4: begin r = (m >> 1) | (c != 0 ? sb : 0); fc = m & 1; end
          5: r = (m + 1) & msk;
          default: r = (m - 1) & msk;
        endcase
        fn = (r & sb) != 0;
        fz = (r == 0);
      end
    endcase
  endfunction

  task automatic run(input string tag, input int w, input int op, input int a, input int m,
                     input int c, input int v, input int d);
    int er, en, ev, ez, ec, gr, gn, gv, gz, gc;
    if (w == 8) begin
      op8 = op[2:0]; a8 = a[7:0]; m8 = m[7:0]; c8 = c[0]; v8 = v[0]; d8 = d[0];
    end else begin
      op16 = op[2:0]; a16 = a[15:0]; m16 = m[15:0]; c16 = c[0]; v16 = v[0]; d16 = d[0];
    end
    @(posedge clk);
    @(negedge clk);
    model(w, op, a, m, c, v, d, er, en, ev, ez, ec);
    if (w == 8) begin gr = int'(r8); gn = n8; gv = vo8; gz = z8; gc = co8; end
    else begin gr = int'(r16); gn = n16; gv = vo16; gz = z16; gc = co16; end
    checks++;
    if (gr != er || gn != en || gv != ev || gz != ez || gc != ec) begin
      fails++;
      $display("FAIL %s w=%0d op=%0d a=%h m=%h c=%0d d=%0d: actual r=%h nvzc=%0d%0d%0d%0d expected r=%h nvzc=%0d%0d%0d%0d",
               tag, w, op, a, m, c, d, gr, gn, gv, gz, gc, er, en, ev, ez, ec);
    end
  endtask

  task automatic reset_check(input string tag);
    checks++;
    if (r8 != 0 || n8 || vo8 || z8 || co8 || r16 != 0 || n16 || vo16 || z16 || co16) begin
      fails++;
      $display("FAIL %s reset: actual r8=%h r16=%h flags8=%b%b%b%b expected all 0",
               tag, r8, r16, n8, vo8, z8, co8);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R1: reset holds outputs at zero even with live inputs
    repeat (2) @(negedge clk);
    reset_check("R1");
    op8 = 3'd0; a8 = 8'hFF; m8 = 8'h01; c8 = 1'b1; a16 = 16'hFFFF; m16 = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    reset_check("R1");
    rst_ni = 1'b1;

    // R2 / R3: binary add and subtract
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 256; a += 3)
        for (int m = 0; m < 256; m += 5)
          for (int c = 0; c < 2; c++)
            run(op == 0 ? "R2" : "R3", 8, op, a, m, c, a & 1, 0);

    // R4 / R5 / R6: all packed-decimal operand pairs
    for (int op = 0; op < 2; op++)
      for (int x = 0; x < 100; x++)
        for (int y = 0; y < 100; y++)
          for (int c = 0; c < 2; c++)
            run(op == 0 ? "R4" : "R5", 8, op, ((x / 10) << 4) | (x % 10),
                ((y / 10) << 4) | (y % 10), c, 0, 1);
    run("R6", 8, 0, 8'h99, 8'h01, 0, 0, 1);
    run("R6", 8, 0, 8'h09, 8'h01, 0, 0, 1);
    run("R6", 8, 1, 8'h00, 8'h01, 1, 0, 1);

    // R7..R10: shifts, rotates, increment, decrement on every operand
    for (int op = 2; op < 7; op++)
      for (int m = 0; m < 256; m++)
        for (int c = 0; c < 2; c++)
          run(op == 2 ? "R7" : op == 3 ? "R8" : op == 4 ? "R9" : "R10",
              8, op, 8'h5A, m, c, (m >> 3) & 1, 0);

    // R11: bit test
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m += 15)
        run("R11", 8, 7, a, m, a & 1, (a >> 1) & 1, 0);

    // R12: decimal flag set on non-arithmetic ops
    for (int op = 2; op < 8; op++)
      for (int m = 0; m < 256; m++)
        for (int c = 0; c < 2; c++)
          run("R12", 8, op, 8'h3C, m, c, m & 1, 1);

    // R13: wide build, sign at bit 15, decimal on low byte only
    run("R13", 16, 0, 16'h7FFF, 16'h0001, 0, 0, 0);
    run("R13", 16, 1, 16'h0000, 16'h0001, 1, 0, 0);
    run("R13", 16, 7, 16'h0001, 16'h4000, 0, 0, 0);
    run("R13", 16, 2, 16'h0000, 16'h8000, 0, 0, 0);
    run("R13", 16, 0, 16'h1299, 16'h0001, 0, 0, 1);
    run("R13", 16, 1, 16'h1200, 16'h0001, 1, 0, 1);
    for (int k = 0; k < 256; k++)
      for (int op = 0; op < 8; op++)
        for (int d = 0; d < 2; d++)
          run("R13", 16, op, (k * 16'h1357 + 16'h0089) & 16'hFFFF,
              (k * 16'h2F1B) & 16'hFFFF, k & 1, (k >> 1) & 1, d);

    report();
  end
endmodule